// File: doc/BRIEF.md
# Prefix-Extended Signed Byte Load Unit

This block executes the signed byte load of a processor with 16-bit instruction words. It also handles the immediate-extension prefix words that can come before that load. A stream of instruction words arrives with a valid qualifier and a flag that marks a branch delay slot. Prefix words are held in a small pending store, which keeps at most two of them. When a load word arrives, the unit reads the base register through an asynchronous register-file read port. It adds a displacement built from the pending prefixes (none, one 13-bit value, or a 24-bit value made from two prefixes) and issues a byte read.

One cycle later, the byte returned by the synchronous memory is written into the destination register. Bits 15:8 of the written value repeat the byte's sign bit, and bits 23:16 are zero. A load in a delay slot ignores any pending prefixes. Any consumed word that is not a prefix empties the pending store. All other instructions are outside this unit.

Top module: `prefix_byte_load`

## Requirements
- R1: A word with bits 15:10 = 001000 and bits 6:3 = 0000 is a load: destination index is bits 9:7 and base index is bits 2:0; the base index is presented on the register read port and one byte read is issued in the same cycle.
- R2: A load with no pending prefix reads the byte at the base register value.
- R3: A prefix word has bits 15:13 = 111 and carries a 13-bit immediate in bits 12:0; a load after one prefix reads at base plus that immediate zero-extended to 24 bits.
- R4: After two prefixes, the displacement is {first[10:0], second[12:0]} (first supplies bits 23:13, second bits 12:0).
- R5: The address sum wraps modulo 2^24.
- R6: The written value has bits 7:0 = loaded byte, bits 15:8 = copies of byte bit 7, bits 23:16 = 0.
- R7: The write to the destination occurs in the cycle after the byte read, addresses only the destination register, and leaves the base register unchanged.
- R8: A load marked as a delay slot uses the plain base value whatever prefixes are pending, and it discards them.
- R9: Any consumed non-prefix word (load or not) empties the pending prefixes; cycles without a valid word keep them. A word that is neither a prefix nor a load issues no read.
- R10: A third consecutive prefix drops the oldest one; the two most recent form the displacement.
- R11: After reset, no byte read and no register write are issued, and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Instruction word |
| instr_delay_slot | input | 1 | Word sits in a branch delay slot |
| rf_rd_addr | output | 3 | Register read index (base) |
| rf_rd_data | input | 24 | Register read data, asynchronous |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_addr | output | 3 | Register write index |
| rf_wr_data | output | 24 | Register write value |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rd_data | input | 8 | Read byte, valid the cycle after the request |

## Verification
The assertions check on every cycle that the pending count never exceeds two, and that a consumed non-prefix word empties the pending store. They also check that idle cycles leave the displacement unchanged, that every read is followed by a write to the captured destination index, and that the upper bits of the write value are zero and the middle bits are sign copies. They further check that a delay-slot load addresses the plain base value. Only the bench's scenarios can show that the one- and two-prefix displacements are assembled in the right bit order, that the address wraps, that a third prefix drops the oldest one, and that the base register is left intact. These are compared against a behavioural memory and register file.

// File: rtl/bld_pkg.sv
package bld_pkg;
    localparam int WORD_W    = 16;
    localparam int IMM_W     = 13;
    localparam int HI_W      = 11;
    localparam int DISP_W    = HI_W + IMM_W;
    localparam logic [5:0] LOAD_OPC = 6'b001000;
    localparam logic [2:0] PFX_TAG  = 3'b111;

    typedef struct packed {
        logic [1:0]       cnt;
        logic [IMM_W-1:0] hi;
        logic [IMM_W-1:0] lo;
    } pfx_state_t;

    function automatic logic is_prefix(input logic [WORD_W-1:0] w);
        return w[15:13] == PFX_TAG;
    endfunction

    function automatic logic is_load(input logic [WORD_W-1:0] w);
        return (w[15:10] == LOAD_OPC) && (w[6:3] == 4'b0000);
    endfunction
endpackage

// File: rtl/bld_prefix_track.sv
module bld_prefix_track
    import bld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic [DISP_W-1:0] disp
);
    pfx_state_t st_d, st_q;
    logic       pfx_w;

    assign pfx_w = is_prefix(in_word);

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (pfx_w) begin
                case (st_q.cnt)
                    2'd0: begin
                        st_d.hi  = in_word[IMM_W-1:0];
                        st_d.cnt = 2'd1;
                    end
                    2'd1: begin
                        st_d.lo  = in_word[IMM_W-1:0];
                        st_d.cnt = 2'd2;
                    end
                    default: begin
                        st_d.hi  = st_q.lo;
                        st_d.lo  = in_word[IMM_W-1:0];
                        st_d.cnt = 2'd2;
                    end
                endcase
            end else begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.cnt)
            2'd0:    disp = '0;
            2'd1:    disp = {{HI_W{1'b0}}, st_q.hi};
            default: disp = {st_q.hi[HI_W-1:0], st_q.lo};
        endcase
    end

    a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != 2'd3);
    a_r9_flush_on_other: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pfx_w) |=> (disp == '0));
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(disp));
endmodule

// File: rtl/bld_addr_gen.sv
module bld_addr_gen
    import bld_pkg::*;
#(
    parameter int REG_W = 24
) (
    input  logic [REG_W-1:0]  base,
    input  logic [DISP_W-1:0] disp,
    input  logic              use_disp,
    output logic [REG_W-1:0]  addr
);
    logic [REG_W-1:0] disp_x;

    generate
        if (REG_W > DISP_W) begin : g_wide
            assign disp_x = {{(REG_W-DISP_W){1'b0}}, disp};
        end else begin : g_narrow
            assign disp_x = disp[REG_W-1:0];
        end
    endgenerate

    assign addr = base + (use_disp ? disp_x : '0);
endmodule

// File: rtl/bld_wb_stage.sv
module bld_wb_stage #(
    parameter int REG_W  = 24,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [RIDX_W-1:0] issue_dest,
    input  logic [7:0]        mem_byte,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data
);
    typedef struct packed {
        logic              vld;
        logic [RIDX_W-1:0] dst;
    } wb_state_t;

    wb_state_t wb_d, wb_q;

    always_comb begin
        wb_d     = wb_q;
        wb_d.vld = issue;
        if (issue) wb_d.dst = issue_dest;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wr_en   = wb_q.vld;
    assign wr_addr = wb_q.dst;
    assign wr_data = {{(REG_W-16){1'b0}}, {8{mem_byte[7]}}, mem_byte};

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[REG_W-1:16] == '0));
    a_r6_sign_copies: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[15:8] == {8{wr_data[7]}}));
endmodule

// File: rtl/prefix_byte_load.sv
module prefix_byte_load
    import bld_pkg::*;
#(
    parameter int REG_W = 24,
    parameter int NREG  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid,
    input  logic [15:0]              instr_word,
    input  logic                     instr_delay_slot,
    output logic [$clog2(NREG)-1:0]  rf_rd_addr,
    input  logic [REG_W-1:0]         rf_rd_data,
    output logic                     rf_wr_en,
    output logic [$clog2(NREG)-1:0]  rf_wr_addr,
    output logic [REG_W-1:0]         rf_wr_data,
    output logic                     mem_rd_en,
    output logic [REG_W-1:0]         mem_addr,
    input  logic [7:0]               mem_rd_data
);
    localparam int RIDX_W = $clog2(NREG);

    logic              ld_hit;
    logic [DISP_W-1:0] disp;
    logic [RIDX_W-1:0] dest_idx;

    assign ld_hit     = instr_valid && is_load(instr_word);
    assign rf_rd_addr = instr_word[RIDX_W-1:0];
    assign dest_idx   = instr_word[7 +: RIDX_W];
    assign mem_rd_en  = ld_hit;

    bld_prefix_track u_pfx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (instr_valid),
        .in_word  (instr_word),
        .disp     (disp)
    );

    bld_addr_gen #(.REG_W(REG_W)) u_agen (
        .base     (rf_rd_data),
        .disp     (disp),
        .use_disp (!instr_delay_slot),
        .addr     (mem_addr)
    );

    bld_wb_stage #(.REG_W(REG_W), .RIDX_W(RIDX_W)) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (ld_hit),
        .issue_dest (dest_idx),
        .mem_byte   (mem_rd_data),
        .wr_en      (rf_wr_en),
        .wr_addr    (rf_wr_addr),
        .wr_data    (rf_wr_data)
    );

    a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (rf_wr_en && rf_wr_addr == $past(instr_word[9:7])));
    a_r7_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_en |=> !rf_wr_en);
    a_r8_delay_slot_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && instr_delay_slot) |-> (mem_addr == rf_rd_data));
    a_r9_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !mem_rd_en);
endmodule

// File: tb/sim_prefix_byte_load.sv
module sim_prefix_byte_load;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0;
    logic        instr_delay_slot = 1'b0;
    logic [2:0]  rf_rd_addr;
    logic [23:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_addr;
    logic [23:0] rf_wr_data;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rd_data = 8'h0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [23:0] rf_m [8];
    logic [23:0] exp_addr_q [$];
    logic [26:0] exp_wr_q [$];

    int          pc = 0;
    logic [12:0] ph = 0, pl = 0;

    always #5 clk = ~clk;

    prefix_byte_load u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_delay_slot(instr_delay_slot), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [7:0] mbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign rf_rd_data = rf_m[rf_rd_addr];

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mbyte(mem_addr);
        if (rf_wr_en) rf_m[rf_wr_addr] <= rf_wr_data;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard items as the design produces them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_rd_en) begin
                if (exp_addr_q.size() == 0) chk(0, "R9 unexpected read", {8'h0, mem_addr}, 32'h0);
                else begin
                    logic [23:0] ea;
                    ea = exp_addr_q.pop_front();
                    chk(mem_addr == ea, "R2/R3/R4/R5/R8 address", {8'h0, mem_addr}, {8'h0, ea});
                end
            end
            if (rf_wr_en) begin
                if (exp_wr_q.size() == 0) chk(0, "R7 unexpected write", {5'h0, rf_wr_addr, rf_wr_data}, 32'h0);
                else begin
                    logic [26:0] ew;
                    ew = exp_wr_q.pop_front();
                    chk({rf_wr_addr, rf_wr_data} == ew, "R6/R7 write dest+data",
                        {5'h0, rf_wr_addr, rf_wr_data}, {5'h0, ew});
                end
            end
        end
    end

    task automatic drive(input logic [15:0] w, input bit ds);
        @(posedge clk); #1;
        instr_valid = 1'b1; instr_word = w; instr_delay_slot = ds;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            instr_valid = 1'b0; instr_delay_slot = 1'b0; instr_word = 16'h0;
        end
    endtask

    task automatic pfx(input logic [12:0] imm);
        drive({3'b111, imm}, 1'b0);
        if (pc == 0) begin ph = imm; pc = 1; end
        else if (pc == 1) begin pl = imm; pc = 2; end
        else begin ph = pl; pl = imm; end
    endtask

    task automatic other(input logic [15:0] w);
        drive(w, 1'b0);
        pc = 0;
    endtask

    task automatic load(input logic [2:0] rd, input logic [2:0] rb, input bit ds);
        logic [23:0] d, a;
        logic [7:0]  b;
        if (ds || pc == 0) d = 24'h0;
        else if (pc == 1)  d = {11'h0, ph};
        else               d = {ph[10:0], pl};
        a = rf_m[rb] + d;
        b = mbyte(a);
        exp_addr_q.push_back(a);
        exp_wr_q.push_back({rd, 8'h00, {8{b[7]}}, b});
        drive({6'b001000, rd, 4'b0000, rb}, ds);
        pc = 0;
        idle(3);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rf_m[0] = 24'h000100; rf_m[1] = 24'h001234; rf_m[2] = 24'hFFFFF0;
        rf_m[3] = 24'h7FFF00; rf_m[4] = 24'h0; rf_m[5] = 24'h0;
        rf_m[6] = 24'h0;      rf_m[7] = 24'h0000C0;
        repeat (3) @(posedge clk);
        #1;
        // R11: nothing issued in reset
        chk(!mem_rd_en && !rf_wr_en, "R11 reset outputs", {mem_rd_en, rf_wr_en}, 0);
        rst_n = 1'b1;
        idle(2);
        chk(!mem_rd_en && !rf_wr_en, "R11 after reset", {mem_rd_en, rf_wr_en}, 0);

        load(3'd4, 3'd1, 0);                 // R1 R2 positive byte
        load(3'd5, 3'd7, 0);                 // R2 R6 negative byte
        pfx(13'h1FFF); load(3'd6, 3'd1, 0);  // R3 max one-prefix
        pfx(13'h05A5); pfx(13'h0F0F); load(3'd4, 3'd3, 0); // R4
        pfx(13'h0020); load(3'd5, 3'd2, 0);  // R5 wrap
        pfx(13'h07FF); pfx(13'h1FFF); load(3'd6, 3'd2, 0); // R5 two-prefix wrap
        pfx(13'h0100); load(3'd4, 3'd0, 1);  // R8 delay slot ignores prefix
        load(3'd5, 3'd0, 0);                 // R8 prefix discarded
        pfx(13'h0300); other(16'h0000); load(3'd6, 3'd7, 0); // R9 flush
        pfx(13'h0044); idle(4); load(3'd4, 3'd7, 0);         // R9 hold over idle
        pfx(13'h0001); pfx(13'h0002); pfx(13'h0003); load(3'd5, 3'd0, 0); // R10

        // R9: load opcode but bits 6:3 nonzero is not a load, no read
        drive(16'b001000_101_0100_001, 1'b0); pc = 0;
        @(negedge clk);
        chk(!mem_rd_en, "R9 non-load no read", mem_rd_en, 0);
        idle(3);

        // R7: base register kept
        chk(rf_m[1] == 24'h001234, "R7 base r1 kept", rf_m[1], 24'h001234);
        chk(rf_m[7] == 24'h0000C0, "R7 base r7 kept", rf_m[7], 24'h0000C0);
        chk(exp_addr_q.size() == 0 && exp_wr_q.size() == 0, "R7 scoreboard drained",
            exp_wr_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule